// File: doc/BRIEF.md
# Memory Card Transfer Buffer with Data Request

The block sits between a processor bus, shared by the CPU and a DMA master, and a serial memory card protocol engine. It holds a small FIFO of 64-bit words. Software or DMA moves words through one data register. The protocol engine moves words through a valid/ready word stream on the other side. A command register sets the transfer size in bytes and the direction. A start strobe from the engine begins the transfer, and an abort strobe cancels it.

While a transfer has bytes left, the block raises a DMA request line and sets a request bit in its status register. The request is held off whenever the FIFO cannot serve the current direction: full for host-to-card, empty for card-to-host. It ends for good when the byte counter reaches zero. Status bits also record protocol completion, CRC and timeout errors, card interrupts, card insertion or removal, and bus overrun or underrun. Enable and disable registers set a mask that gates the interrupt output.

Top module: `mc_xfer_buf`

## Requirements
- R1: Register word addresses are 0 data, 1 command, 2 status, 3 enable, 4 disable and 5 mask. The FIFO holds DEPTH (4) words of 64 bits in arrival order. In host-to-card mode (command bit 31 = 1), data-register writes push and the engine stream pops. In card-to-host mode (bit 31 = 0), the engine stream pushes and data-register reads pop. A data-register access against the current direction changes no FIFO state.
- R2: On `eng_start_i`, the remaining-byte counter loads command bits [15:0] with bits [2:0] forced to zero. The counter drops by 8 for each word the bus side moves in the current direction while it is non-zero.
- R3: `dma_req_o` is high exactly when the counter is non-zero and the FIFO is not full (host-to-card) or not empty (card-to-host).
- R4: Once the counter is zero, `dma_req_o` stays low until the next start, whatever the FIFO does.
- R5: Status bit 1 is set on each rising edge of the request. Any bus access to the data register clears it. A status read does not clear it.
- R6: `eng_end_i` sets status bit 0 when neither error flag is set, bit 3 when `eng_crc_err_i` is set, and bit 4 when `eng_tout_i` is set.
- R7: `card_irq_i` sets status bit 2, and `card_det_i` sets status bit 5.
- R8: A data write in host-to-card mode while the FIFO is full is dropped and sets status bit 6. A data read in card-to-host mode while the FIFO is empty sets status bit 7. Neither changes the counter.
- R9: A status read clears every status bit except bit 1. An event in the same cycle as the read remains set.
- R10: Writing 1s to the enable register sets those mask bits. Writing 1s to the disable register clears them. The mask register reads back the current mask.
- R11: `irq_o` is high exactly when some status bit and its mask bit are both set.
- R12: A start or abort strobe empties the FIFO. An abort zeroes the counter.
- R13: After reset, status, mask, counter and FIFO are empty or zero, and `dma_req_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | Bus write (1) or read (0) |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 64 | Bus write data |
| bus_rdata_o | output | 64 | Bus read data, combinational |
| dma_req_o | output | 1 | DMA data request |
| irq_o | output | 1 | Interrupt request |
| eng_start_i | input | 1 | Command start strobe |
| eng_abort_i | input | 1 | Abort strobe |
| eng_end_i | input | 1 | Protocol end strobe |
| eng_crc_err_i | input | 1 | End came with CRC error |
| eng_tout_i | input | 1 | End came with timeout |
| card_irq_i | input | 1 | Card interrupt strobe |
| card_det_i | input | 1 | Card inserted or removed strobe |
| eng_wvalid_i | input | 1 | Engine word to FIFO valid |
| eng_wdata_i | input | 64 | Engine word to FIFO |
| eng_wready_o | output | 1 | FIFO accepts engine word |
| eng_rvalid_o | output | 1 | FIFO word for engine valid |
| eng_rdata_o | output | 64 | FIFO word for engine |
| eng_rready_i | input | 1 | Engine takes FIFO word |

## Verification
The request logic is tried with a host-to-card transfer that fills the FIFO, overruns it, is partly drained and then completes. This separates the full-FIFO gate from the end-of-count gate. A card-to-host transfer with a size whose low bits are not zero starts from an empty FIFO. It checks the empty gate, the underrun flag and the rounding of the size, and it shows that words arriving after the count ends raise no request. The interrupt path is walked through a table that pairs each event source with masks that include or exclude it, so that a wrong bit position or a mask that is ignored shows up. An abort, followed by a data access against the current direction, checks that the FIFO is flushed and that the wrong-direction access leaves it untouched.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_CMD  = 3'd1,
    REG_STAT = 3'd2,
    REG_IEN  = 3'd3,
    REG_IDIS = 3'd4,
    REG_MASK = 3'd5
  } reg_addr_e;

  localparam int NUM_SRC   = 8;
  localparam int ST_END    = 0;
  localparam int ST_DRQ    = 1;
  localparam int ST_CARD   = 2;
  localparam int ST_CRC    = 3;
  localparam int ST_TOUT   = 4;
  localparam int ST_DET    = 5;
  localparam int ST_OVR    = 6;
  localparam int ST_UDR    = 7;
  localparam int DIR_BIT   = 31;
endpackage

// File: rtl/mcx_fifo.sv
module mcx_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level;
  logic              do_push, do_pop;

  assign full_o  = (level == LVL_W'(DEPTH));
  assign empty_o = (level == '0);
  assign level_o = level;
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] inc_ptr(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= inc_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= inc_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/mcx_req_ctrl.sv
module mcx_req_ctrl #(
  parameter int SIZE_W = 16,
  parameter int WORD_BYTES = 8,
  localparam int LOW_W = $clog2(WORD_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [SIZE_W-LOW_W-1:0] size_words_i,
  input  logic              word_done_i,
  input  logic              dir_wr_i,
  input  logic              full_i,
  input  logic              empty_i,
  output logic              req_o,
  output logic              req_rise_o,
  output logic [SIZE_W-1:0] remain_o
);
  logic [SIZE_W-1:0] remain;
  logic              req_q;
  logic              room;

  assign room       = dir_wr_i ? !full_i : !empty_i;
  assign req_o      = (remain != '0) && room;
  assign req_rise_o = req_o && !req_q;
  assign remain_o   = remain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q <= req_o;
      if (abort_i)
        remain <= '0;
      else if (start_i)
        remain <= {size_words_i, {LOW_W{1'b0}}};
      else if (word_done_i && remain != '0)
        remain <= remain - SIZE_W'(WORD_BYTES);
    end
  end
endmodule

// File: rtl/mcx_irq.sv
module mcx_irq #(
  parameter int NSRC = 8,
  parameter int KEEP_BIT = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            keep_clr_i,
  input  logic            stat_rd_i,
  input  logic            ien_we_i,
  input  logic            idis_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] status, mask;
  logic [NSRC-1:0] status_nx, mask_nx;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      status_nx[i] = status[i];
      if (i == KEEP_BIT) begin
        if (keep_clr_i) status_nx[i] = 1'b0;
      end else if (stat_rd_i) begin
        status_nx[i] = 1'b0;
      end
      if (set_i[i]) status_nx[i] = 1'b1;
    end
  end

  always_comb begin
    mask_nx = mask;
    if (ien_we_i)  mask_nx = mask_nx | wdata_i;
    if (idis_we_i) mask_nx = mask_nx & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= status_nx;
      mask   <= mask_nx;
    end
  end

  assign status_o = status;
  assign mask_o   = mask;
  assign irq_o    = |(status & mask);
endmodule

// File: rtl/mc_xfer_buf.sv
module mc_xfer_buf
  import mcx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int SIZE_W = 16,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int LOW_W = $clog2(WORD_BYTES),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              dma_req_o,
  output logic              irq_o,
  input  logic              eng_start_i,
  input  logic              eng_abort_i,
  input  logic              eng_end_i,
  input  logic              eng_crc_err_i,
  input  logic              eng_tout_i,
  input  logic              card_irq_i,
  input  logic              card_det_i,
  input  logic              eng_wvalid_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  output logic              eng_wready_o,
  output logic              eng_rvalid_o,
  output logic [DATA_W-1:0] eng_rdata_o,
  input  logic              eng_rready_i
);
  logic [SIZE_W-1:0]  cmd_size;
  logic               dir_wr;
  logic               data_acc, data_wr, data_rd;
  logic               stat_rd, ien_we, idis_we, cmd_we;
  logic               fifo_push, fifo_pop, fifo_full, fifo_empty, flush;
  logic [DATA_W-1:0]  fifo_wdata, fifo_head;
  logic [LVL_W-1:0]   fifo_level;
  logic               bus_push_ok, bus_pop_ok, overrun, underrun;
  logic               req, req_rise;
  logic [SIZE_W-1:0]  remain;
  logic [NUM_SRC-1:0] ev_set, status, mask;

  assign data_acc = bus_sel_i && bus_addr_i == REG_DATA;
  assign data_wr  = data_acc && bus_we_i && dir_wr;
  assign data_rd  = data_acc && !bus_we_i && !dir_wr;
  assign cmd_we   = bus_sel_i && bus_we_i && bus_addr_i == REG_CMD;
  assign stat_rd  = bus_sel_i && !bus_we_i && bus_addr_i == REG_STAT;
  assign ien_we   = bus_sel_i && bus_we_i && bus_addr_i == REG_IEN;
  assign idis_we  = bus_sel_i && bus_we_i && bus_addr_i == REG_IDIS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_size <= '0;
      dir_wr   <= 1'b0;
    end else if (cmd_we) begin
      cmd_size <= bus_wdata_i[SIZE_W-1:0];
      dir_wr   <= bus_wdata_i[DIR_BIT];
    end
  end

  // Direction picks which side feeds and which side drains the FIFO.
  assign bus_push_ok  = data_wr && !fifo_full;
  assign bus_pop_ok   = data_rd && !fifo_empty;
  assign overrun      = data_wr && fifo_full;
  assign underrun     = data_rd && fifo_empty;
  assign eng_wready_o = !dir_wr && !fifo_full;
  assign eng_rvalid_o = dir_wr && !fifo_empty;
  assign eng_rdata_o  = fifo_head;
  assign fifo_push    = dir_wr ? bus_push_ok : (eng_wvalid_i && eng_wready_o);
  assign fifo_pop     = dir_wr ? (eng_rready_i && eng_rvalid_o) : bus_pop_ok;
  assign fifo_wdata   = dir_wr ? bus_wdata_i : eng_wdata_i;
  assign flush        = eng_start_i || eng_abort_i;

  mcx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (fifo_push),
    .wdata_i (fifo_wdata),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_head),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .level_o (fifo_level)
  );

  mcx_req_ctrl #(.SIZE_W(SIZE_W), .WORD_BYTES(WORD_BYTES)) u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (eng_start_i),
    .abort_i      (eng_abort_i),
    .size_words_i (cmd_size[SIZE_W-1:LOW_W]),
    .word_done_i  (bus_push_ok || bus_pop_ok),
    .dir_wr_i     (dir_wr),
    .full_i       (fifo_full),
    .empty_i      (fifo_empty),
    .req_o        (req),
    .req_rise_o   (req_rise),
    .remain_o     (remain)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[ST_END]  = eng_end_i && !eng_crc_err_i && !eng_tout_i;
    ev_set[ST_DRQ]  = req_rise;
    ev_set[ST_CARD] = card_irq_i;
    ev_set[ST_CRC]  = eng_end_i && eng_crc_err_i;
    ev_set[ST_TOUT] = eng_end_i && eng_tout_i;
    ev_set[ST_DET]  = card_det_i;
    ev_set[ST_OVR]  = overrun;
    ev_set[ST_UDR]  = underrun;
  end

  mcx_irq #(.NSRC(NUM_SRC), .KEEP_BIT(ST_DRQ)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (ev_set),
    .keep_clr_i (data_acc),
    .stat_rd_i  (stat_rd),
    .ien_we_i   (ien_we),
    .idis_we_i  (idis_we),
    .wdata_i    (bus_wdata_i[NUM_SRC-1:0]),
    .status_o   (status),
    .mask_o     (mask),
    .irq_o      (irq_o)
  );

  assign dma_req_o = req;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      REG_DATA: if (!dir_wr) bus_rdata_o = fifo_head;
      REG_CMD: begin
        bus_rdata_o[SIZE_W-1:0] = cmd_size;
        bus_rdata_o[DIR_BIT]    = dir_wr;
      end
      REG_STAT: bus_rdata_o[NUM_SRC-1:0] = status;
      REG_MASK: bus_rdata_o[NUM_SRC-1:0] = mask;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mcx_checker.sv
module mcx_checker #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int SIZE_W = 16,
  parameter int LVL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [2:0]        bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              dma_req_o,
  input logic              irq_o,
  input logic              eng_start_i,
  input logic              eng_abort_i,
  input logic              eng_end_i,
  input logic              card_irq_i,
  input logic              card_det_i,
  input logic [SIZE_W-1:0] remain,
  input logic [SIZE_W-1:0] cmd_size,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              fifo_full,
  input logic              dir_wr,
  input logic              req_rise,
  input logic [7:0]        status,
  input logic [7:0]        mask
);
  localparam logic [SIZE_W-1:0] SZ_MASK = {{(SIZE_W-3){1'b1}}, 3'b000};
  logic acc_data, rd_stat, w_ien, w_idis;
  assign acc_data = bus_sel_i && bus_addr_i == 3'd0;
  assign rd_stat  = bus_sel_i && !bus_we_i && bus_addr_i == 3'd2;
  assign w_ien    = bus_sel_i && bus_we_i && bus_addr_i == 3'd3;
  assign w_idis   = bus_sel_i && bus_we_i && bus_addr_i == 3'd4;

  p_fifo_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= LVL_W'(DEPTH));

  p_cnt_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_i && !eng_abort_i) |=> remain == ($past(cmd_size) & SZ_MASK));

  p_req_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> remain != '0);

  p_done_sticks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain == '0 && !eng_start_i) |=> (remain == '0 && !dma_req_o));

  p_drq_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_data && !req_rise) |=> !status[1]);

  p_ovr_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_data && bus_we_i && dir_wr && fifo_full) |=> status[6]);

  p_cor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !eng_end_i && !card_irq_i && !card_det_i) |=> (status & 8'hFD) == 8'h00);

  p_ien_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_ien && !w_idis) |=> (mask & $past(bus_wdata_i[7:0])) == $past(bus_wdata_i[7:0]));

  p_idis_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_idis |=> (mask & $past(bus_wdata_i[7:0])) == 8'h00);

  p_irq_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == 8'h00) |-> !irq_o);

  p_abort_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_abort_i |=> (fifo_level == '0 && remain == '0));
endmodule

bind mc_xfer_buf mcx_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .SIZE_W(SIZE_W), .LVL_W(LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .dma_req_o   (dma_req_o),
  .irq_o       (irq_o),
  .eng_start_i (eng_start_i),
  .eng_abort_i (eng_abort_i),
  .eng_end_i   (eng_end_i),
  .card_irq_i  (card_irq_i),
  .card_det_i  (card_det_i),
  .remain      (remain),
  .cmd_size    (cmd_size),
  .fifo_level  (fifo_level),
  .fifo_full   (fifo_full),
  .dir_wr      (dir_wr),
  .req_rise    (req_rise),
  .status      (status),
  .mask        (mask)
);

// File: tb/tb_mc_xfer_buf.sv
module tb_mc_xfer_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 0, we = 0;
  logic [2:0]  addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        dma_req, irq;
  logic        start = 0, abort = 0, eend = 0, crc = 0, tout = 0, cirq = 0, cdet = 0;
  logic        ewvalid = 0, ewready, ervalid, errdy = 0;
  logic [63:0] ewdata = '0, erdata;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  mc_xfer_buf dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dma_req_o(dma_req), .irq_o(irq),
    .eng_start_i(start), .eng_abort_i(abort), .eng_end_i(eend), .eng_crc_err_i(crc),
    .eng_tout_i(tout), .card_irq_i(cirq), .card_det_i(cdet), .eng_wvalid_i(ewvalid),
    .eng_wdata_i(ewdata), .eng_wready_o(ewready), .eng_rvalid_o(ervalid),
    .eng_rdata_o(erdata), .eng_rready_i(errdy)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [2:0] a, input logic [63:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [63:0] d);
    sel = 1; we = 0; addr = a;
    #5 d = rdata;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic pulse_abort();
    abort = 1; @(negedge clk); abort = 0;
  endtask

  task automatic fire(input int code);
    case (code)
      0: eend = 1;
      1: begin eend = 1; crc = 1; end
      2: begin eend = 1; tout = 1; end
      3: cirq = 1;
      default: cdet = 1;
    endcase
    @(negedge clk);
    eend = 0; crc = 0; tout = 0; cirq = 0; cdet = 0;
  endtask

  task automatic eng_pop(output logic [63:0] d);
    errdy = 1;
    #5 d = erdata;
    @(negedge clk);
    errdy = 0;
  endtask

  task automatic eng_push(input logic [63:0] d);
    ewvalid = 1; ewdata = d;
    @(negedge clk);
    ewvalid = 0;
  endtask

  // {mask[7:0], event[2:0], expected status[7:0], expected irq}
  localparam logic [19:0] VEC [8] = '{
    {8'h01, 3'd0, 8'h01, 1'b1},
    {8'h00, 3'd0, 8'h01, 1'b0},
    {8'h08, 3'd1, 8'h08, 1'b1},
    {8'h08, 3'd2, 8'h10, 1'b0},
    {8'h10, 3'd2, 8'h10, 1'b1},
    {8'h04, 3'd3, 8'h04, 1'b1},
    {8'hDB, 3'd4, 8'h20, 1'b0},
    {8'h20, 3'd4, 8'h20, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    idle(2);
    rst_n = 1;
    idle(1);
    // R13 reset state
    chk(!dma_req && !irq, "R13", {dma_req, irq}, 0);
    brd(3'd2, d); chk(d == 0, "R13", d, 0);
    brd(3'd5, d); chk(d == 0, "R13", d, 0);

    // Interrupt table: R6 R7 R10 R11 R9
    foreach (VEC[i]) begin
      logic [7:0] m, es; logic [2:0] ev; logic ei;
      {m, ev, es, ei} = VEC[i];
      bwr(3'd4, 64'hFF);
      bwr(3'd3, {56'h0, m});
      brd(3'd5, d); chk(d[7:0] == m, "R10", d, m);
      fire(int'(ev));
      chk(irq == ei, "R11", irq, ei);
      brd(3'd2, d); chk(d[7:0] == es, (ev < 3) ? "R6" : "R7", d, es);
      chk(irq == 0, "R9", irq, 0);
      brd(3'd2, d); chk(d[7:0] == 0, "R9", d, 0);
    end
    // R9: event in the same cycle as the status read stays set
    sel = 1; we = 0; addr = 3'd2; cdet = 1;
    @(negedge clk); sel = 0; cdet = 0;
    brd(3'd2, d); chk(d[7:0] == 8'h20, "R9", d, 8'h20);
    bwr(3'd4, 64'hFF);

    // Host-to-card transfer, 40 bytes (5 words)
    bwr(3'd1, 64'h8000_0028);
    pulse_start();
    chk(dma_req == 1, "R3", dma_req, 1);
    idle(1);
    brd(3'd2, d); chk(d[1] == 1, "R5", d, 2);
    brd(3'd2, d); chk(d[1] == 1, "R5", d, 2);
    bwr(3'd0, 64'hA1);
    brd(3'd2, d); chk(d[1] == 0, "R5", d, 0);
    bwr(3'd0, 64'hA2); bwr(3'd0, 64'hA3);
    chk(dma_req == 1, "R3", dma_req, 1);
    bwr(3'd0, 64'hA4);
    chk(dma_req == 0, "R3", dma_req, 0);
    bwr(3'd0, 64'hEE);
    brd(3'd2, d); chk(d[6] == 1, "R8", d, 8'h40);
    eng_pop(d); chk(d == 64'hA1, "R1", d, 64'hA1);
    chk(dma_req == 1, "R8", dma_req, 1);
    bwr(3'd0, 64'hA5);
    chk(dma_req == 0, "R2", dma_req, 0);
    eng_pop(d); chk(d == 64'hA2, "R1", d, 64'hA2);
    eng_pop(d); chk(d == 64'hA3, "R1", d, 64'hA3);
    eng_pop(d); chk(d == 64'hA4, "R1", d, 64'hA4);
    eng_pop(d); chk(d == 64'hA5, "R8", d, 64'hA5);
    chk(ervalid == 0 && dma_req == 0, "R4", {ervalid, dma_req}, 0);

    // Card-to-host transfer, size 19 rounds down to 16 bytes
    bwr(3'd1, 64'h0000_0013);
    pulse_start();
    chk(dma_req == 0, "R3", dma_req, 0);
    brd(3'd0, d);
    brd(3'd2, d); chk(d[7:0] == 8'h80, "R8", d, 8'h80);
    eng_push(64'hB1);
    chk(dma_req == 1, "R3", dma_req, 1);
    brd(3'd0, d); chk(d == 64'hB1, "R1", d, 64'hB1);
    eng_push(64'hB2);
    brd(3'd0, d); chk(d == 64'hB2, "R1", d, 64'hB2);
    chk(dma_req == 0, "R2", dma_req, 0);
    eng_push(64'hB3);
    chk(dma_req == 0 && ewready == 1, "R4", {dma_req, ewready}, 1);

    // Abort and wrong-direction access
    pulse_abort();
    bwr(3'd0, 64'hC1);
    brd(3'd2, d);
    brd(3'd0, d);
    brd(3'd2, d); chk(d[7:0] == 8'h80, "R12", d, 8'h80);
    bwr(3'd1, 64'h8000_0040);
    pulse_start();
    bwr(3'd0, 64'hD1); bwr(3'd0, 64'hD2);
    pulse_abort();
    chk(dma_req == 0 && ervalid == 0, "R12", {dma_req, ervalid}, 0);
    brd(3'd0, d); chk(d == 0, "R1", d, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule